// File: doc/BRIEF.md
# Trim Code Centring Calibrator

This block calibrates one analog trim at a time. Software, or a higher-level sequencer, picks the trim to tune and gives a settle delay and the code that is currently programmed, then pulses start. The calibrator drives the test-mode bits that the chosen trim needs. It then writes trim codes from zero upward through a simple register-write strobe. After each write it waits for the settle delay and samples the status flags that report whether the code passes. If no code passes, it writes back the code that was programmed before.

The result is the midpoint of the first contiguous run of passing codes, not the first passing code. This keeps the trim away from both edges of its passing window. When the run closes, or the last code has been tried, the calibrator writes the result. It then clears the test bits and pulses done. A failure flag reports that no code passed.

Three trims are supported. Two are 4 bits wide: an oscillator trim judged by a pair of flags, and a narrow filter trim. The third is a 6-bit wide filter trim. Each trim has its own pass rule and its own test-mode setup.

Top module: `trim_centre_cal`

## Requirements
- R1: After synchronous reset, `done_o`, `fail_o`, `wr_o`, `flt_test_o` and `dac_test_o` are all 0, and no write is issued until a start is accepted.
- R2: A start in idle with `trim_sel_i` = 0 (oscillator, 4 bits), 1 (wide filter, 6 bits) or 2 (narrow filter, 4 bits) begins a sweep. The sweep writes codes 0, 1, 2, … in order, and every write carries `wr_sel_o` equal to the selected trim. Codes for the 4-bit trims never exceed 15.
- R3: Each sweep write is followed by `settle_i`+1 cycles of waiting. The flags are sampled in the last of those cycles, so consecutive writes of one calibration are `settle_i`+2 cycles apart.
- R4: During a calibration the test bits are set as follows. Oscillator: `flt_test_o`=0 and `dac_test_o`=0. Wide filter: `flt_test_o`=1 and `dac_test_o`=0. Narrow filter: `flt_test_o`=1 and `dac_test_o`=0.
- R5: The pass rule depends on the trim. Oscillator: `stat_i[0]`=0 and `stat_i[1]`=1. Wide filter: `stat_i[2]`=1. Narrow filter: `stat_i[3]`=1. Other bits of `stat_i` are ignored.
- R6: Only the first contiguous passing run counts. The sweep stops at the first failing code after that run; otherwise it ends at the trim's top code (15 or 63).
- R7: When a run was found, the final write carries floor((first+last)/2), and `fail_o` is 0 at done.
- R8: When no code passes, the final write carries the `prev_code_i` value captured at start, and `fail_o` is 1 at done.
- R9: `done_o` is high for exactly one cycle. The test bits are 0 in that cycle. `fail_o` holds its value until the next accepted start.
- R10: A start pulse while a calibration is running is ignored. The running calibration ends with its own result, and no write goes to another trim.
- R11: `trim_sel_i` = 3 is reserved. A start with it gives done and `fail_o`=1 in the next cycle, with no write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | One-cycle request to calibrate |
| trim_sel_i | input | 2 | Trim to calibrate (0 oscillator, 1 wide filter, 2 narrow filter, 3 reserved) |
| settle_i | input | SETTLE_W | Extra cycles to wait after each write before sampling |
| prev_code_i | input | 6 | Code currently programmed, restored on failure |
| stat_i | input | 4 | Status flags from the analog trims |
| wr_o | output | 1 | Trim register write strobe |
| wr_sel_o | output | 2 | Trim addressed by the write |
| wr_code_o | output | 6 | Code written |
| flt_test_o | output | 1 | Filter test-mode bit |
| dac_test_o | output | 1 | DAC test-mode bit |
| done_o | output | 1 | One-cycle completion pulse |
| fail_o | output | 1 | No passing code found, or reserved selection |

## Verification
Two events can land on the same sampling cycle: the close of the passing run and the end of the sweep at the trim's top code. The bench provokes this with a wide-filter window of 60 to 63. The run is still open when code 63 is sampled, so the block must take 63 as the last passing code and write 61. A run that closes early, and two separate windows, show that the sweep normally stops at the first failing code after a run. The flag model inverts its answer until `settle_i` cycles after each write, so sampling too early shows up as a wrong centre code.

// File: rtl/tcc_pkg.sv
package tcc_pkg;

    localparam int CODE_W   = 6;
    localparam int NARROW_W = 4;
    localparam int STAT_W   = 4;
    localparam int SEL_W    = 2;

    // status flag positions
    localparam int ST_OSC_LO = 0;   // must read 0 for the oscillator trim
    localparam int ST_OSC_HI = 1;   // must read 1 for the oscillator trim
    localparam int ST_WFLT   = 2;
    localparam int ST_NFLT   = 3;

    typedef enum logic [SEL_W-1:0] {
        TRIM_OSC  = 2'd0,
        TRIM_WFLT = 2'd1,
        TRIM_NFLT = 2'd2,
        TRIM_RSVD = 2'd3
    } trim_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WRITE,
        ST_SETTLE,
        ST_FINAL,
        ST_DONE
    } state_e;

    typedef struct packed {
        logic              valid;
        logic [CODE_W-1:0] top;
        logic              flt_test;
        logic              dac_test;
    } profile_t;

    function automatic profile_t profile_of(trim_e t);
        profile_t p;
        p = '{valid: 1'b0, top: '0, flt_test: 1'b0, dac_test: 1'b0};
        case (t)
            TRIM_OSC: begin
                p.valid = 1'b1;
                p.top   = CODE_W'((1 << NARROW_W) - 1);
            end
            TRIM_WFLT: begin
                p.valid    = 1'b1;
                p.top      = CODE_W'((1 << CODE_W) - 1);
                p.flt_test = 1'b1;
            end
            TRIM_NFLT: begin
                p.valid    = 1'b1;
                p.top      = CODE_W'((1 << NARROW_W) - 1);
                p.flt_test = 1'b1;
            end
            default: p.valid = 1'b0;
        endcase
        return p;
    endfunction

    function automatic logic [CODE_W-1:0] centre(logic [CODE_W-1:0] lo,
                                                 logic [CODE_W-1:0] hi);
        logic [CODE_W:0] sum;
        sum = {1'b0, lo} + {1'b0, hi};
        return sum[CODE_W:1];
    endfunction

endpackage

// File: rtl/tcc_settle_timer.sv
module tcc_settle_timer #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load_i,
    input  logic [W-1:0] load_val_i,
    output logic         expired_o
);
    logic [W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (load_i) begin
            cnt_q <= load_val_i;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign expired_o = (cnt_q == '0);
endmodule

// File: rtl/tcc_pass_eval.sv
module tcc_pass_eval
    import tcc_pkg::*;
(
    input  trim_e             sel_i,
    input  logic [STAT_W-1:0] stat_i,
    output logic              pass_o
);
    always_comb begin
        case (sel_i)
            TRIM_OSC:  pass_o = !stat_i[ST_OSC_LO] && stat_i[ST_OSC_HI];
            TRIM_WFLT: pass_o = stat_i[ST_WFLT];
            TRIM_NFLT: pass_o = stat_i[ST_NFLT];
            default:   pass_o = 1'b0;
        endcase
    end
endmodule

// File: rtl/tcc_window_tracker.sv
module tcc_window_tracker #(
    parameter int W = 6
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clear_i,
    input  logic         sample_i,
    input  logic         pass_i,
    input  logic [W-1:0] code_i,
    output logic         found_o,
    output logic         run_closed_o,
    output logic [W-1:0] first_o,
    output logic [W-1:0] last_o
);
    always_ff @(posedge clk) begin
        if (rst || clear_i) begin
            found_o <= 1'b0;
            first_o <= '0;
            last_o  <= '0;
        end else if (sample_i && pass_i) begin
            if (!found_o) begin
                found_o <= 1'b1;
                first_o <= code_i;
            end
            last_o <= code_i;
        end
    end

    assign run_closed_o = sample_i && !pass_i && found_o;
endmodule

// File: rtl/trim_centre_cal.sv
module trim_centre_cal
    import tcc_pkg::*;
#(
    parameter int SETTLE_W = 8
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                start_i,
    input  logic [SEL_W-1:0]    trim_sel_i,
    input  logic [SETTLE_W-1:0] settle_i,
    input  logic [CODE_W-1:0]   prev_code_i,
    input  logic [STAT_W-1:0]   stat_i,
    output logic                wr_o,
    output logic [SEL_W-1:0]    wr_sel_o,
    output logic [CODE_W-1:0]   wr_code_o,
    output logic                flt_test_o,
    output logic                dac_test_o,
    output logic                done_o,
    output logic                fail_o
);
    state_e              state_q;
    trim_e               sel_q;
    profile_t            prof_q;
    profile_t            prof_in;
    logic [CODE_W-1:0]   code_q;
    logic [CODE_W-1:0]   prev_q;
    logic                fail_q;

    logic                expired;
    logic                pass;
    logic                sample;
    logic                found;
    logic                run_closed;
    logic [CODE_W-1:0]   first_code;
    logic [CODE_W-1:0]   last_code;
    logic                accept;

    assign prof_in = profile_of(trim_e'(trim_sel_i));
    assign accept  = (state_q == ST_IDLE) && start_i;
    assign sample  = (state_q == ST_SETTLE) && expired;

    tcc_settle_timer #(.W(SETTLE_W)) u_timer (
        .clk        (clk),
        .rst        (rst),
        .load_i     (state_q == ST_WRITE),
        .load_val_i (settle_i),
        .expired_o  (expired)
    );

    tcc_pass_eval u_eval (
        .sel_i  (sel_q),
        .stat_i (stat_i),
        .pass_o (pass)
    );

    tcc_window_tracker #(.W(CODE_W)) u_track (
        .clk          (clk),
        .rst          (rst),
        .clear_i      (accept),
        .sample_i     (sample),
        .pass_i       (pass),
        .code_i       (code_q),
        .found_o      (found),
        .run_closed_o (run_closed),
        .first_o      (first_code),
        .last_o       (last_code)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            sel_q   <= TRIM_OSC;
            prof_q  <= '0;
            code_q  <= '0;
            prev_q  <= '0;
            fail_q  <= 1'b0;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    if (start_i) begin
                        sel_q  <= trim_e'(trim_sel_i);
                        prev_q <= prev_code_i;
                        code_q <= '0;
                        if (prof_in.valid) begin
                            prof_q  <= prof_in;
                            fail_q  <= 1'b0;
                            state_q <= ST_WRITE;
                        end else begin
                            prof_q  <= '0;
                            fail_q  <= 1'b1;
                            state_q <= ST_DONE;
                        end
                    end
                end
                ST_WRITE: begin
                    state_q <= ST_SETTLE;
                end
                ST_SETTLE: begin
                    if (sample) begin
                        if (run_closed || code_q == prof_q.top) begin
                            state_q <= ST_FINAL;
                        end else begin
                            code_q  <= code_q + 1'b1;
                            state_q <= ST_WRITE;
                        end
                    end
                end
                ST_FINAL: begin
                    fail_q  <= !found;
                    prof_q  <= '0;
                    state_q <= ST_DONE;
                end
                ST_DONE: begin
                    state_q <= ST_IDLE;
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    always_comb begin
        wr_o      = (state_q == ST_WRITE) || (state_q == ST_FINAL);
        wr_sel_o  = sel_q;
        wr_code_o = code_q;
        if (state_q == ST_FINAL) begin
            wr_code_o = found ? centre(first_code, last_code) : prev_q;
        end
    end

    assign flt_test_o = prof_q.flt_test;
    assign dac_test_o = prof_q.dac_test;
    assign done_o     = (state_q == ST_DONE);
    assign fail_o     = fail_q;
endmodule

// File: rtl/tcc_checker.sv
module tcc_checker
    import tcc_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              wr_o,
    input logic [SEL_W-1:0]  wr_sel_o,
    input logic [CODE_W-1:0] wr_code_o,
    input logic              flt_test_o,
    input logic              dac_test_o,
    input logic              done_o,
    input logic              fail_o
);
    AST_DONE_SINGLE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o); // R9

    AST_DONE_TEST_BITS_LOW: assert property (@(posedge clk) disable iff (rst)
        done_o |-> (!flt_test_o && !dac_test_o)); // R9

    AST_NARROW_CODE_RANGE: assert property (@(posedge clk) disable iff (rst)
        (wr_o && wr_sel_o != 2'd1) |-> ((wr_code_o >> NARROW_W) == '0)); // R2

    AST_OSC_TEST_BITS: assert property (@(posedge clk) disable iff (rst)
        (wr_o && wr_sel_o == 2'd0) |-> (!flt_test_o && !dac_test_o)); // R4

    AST_FILTER_TEST_BITS: assert property (@(posedge clk) disable iff (rst)
        (wr_o && (wr_sel_o == 2'd1 || wr_sel_o == 2'd2)) |-> (flt_test_o && !dac_test_o)); // R4

    AST_FAIL_RISES_AT_DONE: assert property (@(posedge clk) disable iff (rst)
        $rose(fail_o) |-> done_o); // R8

    AST_RESERVED_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
        wr_o |-> (wr_sel_o != 2'd3)); // R11
endmodule

bind trim_centre_cal tcc_checker u_tcc_checker (
    .clk        (clk),
    .rst        (rst),
    .wr_o       (wr_o),
    .wr_sel_o   (wr_sel_o),
    .wr_code_o  (wr_code_o),
    .flt_test_o (flt_test_o),
    .dac_test_o (dac_test_o),
    .done_o     (done_o),
    .fail_o     (fail_o)
);

// File: tb/tb_trim_centre_cal.sv
module tb_trim_centre_cal;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       start_i = 1'b0;
    logic [1:0] trim_sel_i = 2'd0;
    logic [7:0] settle_i = 8'd0;
    logic [5:0] prev_code_i = 6'd0;
    logic [3:0] stat_i;
    logic       wr_o;
    logic [1:0] wr_sel_o;
    logic [5:0] wr_code_o;
    logic       flt_test_o;
    logic       dac_test_o;
    logic       done_o;
    logic       fail_o;

    always #4 clk = ~clk;   // 125 MHz

    trim_centre_cal #(.SETTLE_W(8)) dut (
        .clk         (clk),
        .rst         (rst),
        .start_i     (start_i),
        .trim_sel_i  (trim_sel_i),
        .settle_i    (settle_i),
        .prev_code_i (prev_code_i),
        .stat_i      (stat_i),
        .wr_o        (wr_o),
        .wr_sel_o    (wr_sel_o),
        .wr_code_o   (wr_code_o),
        .flt_test_o  (flt_test_o),
        .dac_test_o  (dac_test_o),
        .done_o      (done_o),
        .fail_o      (fail_o)
    );

    // ---------------- analog trim model ----------------
    logic [1:0] m_sel = 2'd0;
    logic [6:0] m_lo1 = 7'd127, m_hi1 = 7'd0, m_lo2 = 7'd127, m_hi2 = 7'd0;
    logic [5:0] regs [4];
    logic [7:0] age;
    int         wr_count;
    int         bad_sel;
    int         gap_bad;
    int         cyc;
    int         last_wr_cyc;
    logic       seen_wr;

    logic [5:0] cur;
    logic       in_win, mode_ok, good;
    assign cur    = regs[m_sel];
    assign in_win = ({1'b0, cur} >= m_lo1 && {1'b0, cur} <= m_hi1) ||
                    ({1'b0, cur} >= m_lo2 && {1'b0, cur} <= m_hi2);
    always_comb begin
        case (m_sel)
            2'd0:    mode_ok = !flt_test_o && !dac_test_o;
            2'd1:    mode_ok = flt_test_o && !dac_test_o;
            default: mode_ok = flt_test_o;
        endcase
    end
    assign good = in_win && mode_ok && (age >= settle_i);
    always_comb begin
        stat_i = 4'b1110;  // unrelated flags show a passing pattern
        case (m_sel)
            2'd0:    stat_i[1:0] = good ? 2'b10 : (({1'b0, cur} < m_lo1) ? 2'b11 : 2'b00);
            2'd1:    stat_i[2]   = good;
            default: stat_i[3]   = good;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < 4; i++) regs[i] <= 6'd0;
            age         <= 8'd0;
            wr_count    <= 0;
            bad_sel     <= 0;
            gap_bad     <= 0;
            last_wr_cyc <= 0;
            seen_wr     <= 1'b0;
        end else begin
            if (wr_o) begin
                regs[wr_sel_o] <= wr_code_o;
                age            <= 8'd0;
                wr_count       <= wr_count + 1;
                last_wr_cyc    <= cyc;
                seen_wr        <= 1'b1;
                if (wr_sel_o != m_sel) bad_sel <= bad_sel + 1;
                if (seen_wr && (cyc - last_wr_cyc) != int'(settle_i) + 2) gap_bad <= gap_bad + 1;
            end else if (age != 8'hFF) begin
                age <= age + 1'b1;
            end
            if (done_o) seen_wr <= 1'b0;
        end
    end

    // ---------------- checking ----------------
    int errors = 0;
    int checks = 0;
    bit finished = 0;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000 && !finished) begin
            finished = 1;
            errors++;
            checks++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
            $display("  Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
    initial cyc = 0;

    task automatic wait_done(output bit got);
        got = 0;
        for (int i = 0; i < 5000; i++) begin
            @(negedge clk);
            if (done_o) begin got = 1; break; end
        end
    endtask

    typedef struct packed {
        logic [1:0] sel;
        logic [6:0] lo1, hi1, lo2, hi2;
        logic [7:0] settle;
        logic [5:0] prev;
        logic [5:0] exp_code;
        logic       exp_fail;
        logic [7:0] exp_writes;
    } vec_t;

    localparam int NV = 9;
    localparam vec_t VECS [NV] = '{
        '{2'd0, 7'd3,  7'd9,  7'd127, 7'd0,  8'd2, 6'd4,  6'd6,  1'b0, 8'd12}, // oscillator window
        '{2'd1, 7'd10, 7'd20, 7'd127, 7'd0,  8'd1, 6'd33, 6'd15, 1'b0, 8'd23}, // wide filter
        '{2'd2, 7'd0,  7'd0,  7'd127, 7'd0,  8'd0, 6'd9,  6'd0,  1'b0, 8'd3},  // single code at 0
        '{2'd1, 7'd60, 7'd63, 7'd127, 7'd0,  8'd3, 6'd1,  6'd61, 1'b0, 8'd65}, // run open at top
        '{2'd0, 7'd127,7'd0,  7'd127, 7'd0,  8'd1, 6'd7,  6'd7,  1'b1, 8'd17}, // nothing passes
        '{2'd1, 7'd5,  7'd8,  7'd20,  7'd30, 8'd2, 6'd2,  6'd6,  1'b0, 8'd11}, // two windows
        '{2'd2, 7'd4,  7'd11, 7'd127, 7'd0,  8'd5, 6'd3,  6'd7,  1'b0, 8'd14}, // long settle
        '{2'd0, 7'd0,  7'd15, 7'd127, 7'd0,  8'd0, 6'd2,  6'd7,  1'b0, 8'd17}, // all pass
        '{2'd2, 7'd14, 7'd15, 7'd127, 7'd0,  8'd1, 6'd5,  6'd14, 1'b0, 8'd17}  // top pair
    };

    task automatic set_model(input vec_t v);
        m_sel = v.sel; m_lo1 = v.lo1; m_hi1 = v.hi1; m_lo2 = v.lo2; m_hi2 = v.hi2;
        settle_i = v.settle; prev_code_i = v.prev; trim_sel_i = v.sel;
    endtask

    initial begin
        bit got;
        int w0, b0, g0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1: reset state
        check(!done_o && !fail_o && !wr_o, "R1 idle outputs", {done_o, fail_o, wr_o}, 0);
        check(!flt_test_o && !dac_test_o, "R1 test bits", {flt_test_o, dac_test_o}, 0);
        repeat (3) @(negedge clk);
        check(wr_count == 0, "R1 no write before start", wr_count, 0);

        for (int k = 0; k < NV; k++) begin
            set_model(VECS[k]);
            w0 = wr_count; b0 = bad_sel; g0 = gap_bad;
            start_i = 1'b1;
            @(negedge clk);
            start_i = 1'b0;
            wait_done(got);
            check(got, "R9 done reached", got, 1);
            // R7 / R8: result code and failure flag; R5 / R6 via window model
            check(regs[VECS[k].sel] == VECS[k].exp_code, "R7 R8 final code",
                  regs[VECS[k].sel], VECS[k].exp_code);
            check(fail_o == VECS[k].exp_fail, "R8 fail flag", fail_o, VECS[k].exp_fail);
            check(wr_count - w0 == int'(VECS[k].exp_writes), "R6 write count",
                  wr_count - w0, VECS[k].exp_writes);
            check(bad_sel == b0, "R2 write target", bad_sel - b0, 0);
            check(gap_bad == g0, "R3 settle spacing", gap_bad - g0, 0);
            check(!flt_test_o && !dac_test_o, "R9 test bits at done",
                  {flt_test_o, dac_test_o}, 0);
            @(negedge clk);
            check(!done_o, "R9 done one cycle", done_o, 0);
            check(fail_o == VECS[k].exp_fail, "R9 fail held", fail_o, VECS[k].exp_fail);
        end

        // R4: test bits during a wide filter sweep
        set_model(VECS[1]);
        start_i = 1'b1; @(negedge clk); start_i = 1'b0;
        repeat (2) @(negedge clk);
        check(flt_test_o && !dac_test_o, "R4 wide filter test bits",
              {flt_test_o, dac_test_o}, 2);
        wait_done(got);
        @(negedge clk);
        // R4: oscillator sweep keeps both bits low
        set_model(VECS[0]);
        start_i = 1'b1; @(negedge clk); start_i = 1'b0;
        repeat (2) @(negedge clk);
        check(!flt_test_o && !dac_test_o, "R4 oscillator test bits",
              {flt_test_o, dac_test_o}, 0);
        wait_done(got);
        @(negedge clk);

        // R10: start while busy is ignored
        set_model(VECS[1]);
        w0 = wr_count; b0 = bad_sel;
        start_i = 1'b1; @(negedge clk); start_i = 1'b0;
        repeat (10) @(negedge clk);
        trim_sel_i = 2'd2;
        start_i = 1'b1; @(negedge clk); start_i = 1'b0;
        trim_sel_i = 2'd1;
        wait_done(got);
        check(regs[1] == 6'd15, "R10 result unaffected", regs[1], 15);
        check(wr_count - w0 == 23 && bad_sel == b0, "R10 no extra writes", wr_count - w0, 23);
        @(negedge clk);

        // R11: reserved selection
        w0 = wr_count;
        trim_sel_i = 2'd3;
        start_i = 1'b1; @(negedge clk); start_i = 1'b0;
        check(done_o && fail_o, "R11 reserved done with fail", {done_o, fail_o}, 3);
        @(negedge clk);
        check(wr_count == w0, "R11 no write", wr_count - w0, 0);

        finished = 1;
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule